// File: doc/BRIEF.md
# Keyed Write Guard for Control Registers

This block holds a small bank of control registers on a single-cycle register bus and keeps stray writes from changing them. A configuration input `lock_cfg` turns protection on or off. Its intended default is 1, which means protected. While protection is on, a guarded register accepts a write only when that write comes directly after a two-word key written to a dedicated key address. Each key sequence grants exactly one guarded write.

Any other bus access that falls inside the sequence cancels it. This includes reads. A guarded write that is refused leaves the register unchanged and raises a one-cycle reject flag. Reads of the guarded registers always return their contents. Cycles in which `bus_valid` is low are not accesses, so they do not disturb the sequence.

The address map is fixed. The key register sits at address 0. The guarded registers sit at addresses `BASE` to `BASE+NREG-1`, and the defaults place them at 1, 2 and 3. Any other address is unmapped.

Top module: `keyed_reg_guard`

## Requirements
- R1: A synchronous active-high reset has these effects:
  - Guarded register i (0-based) is loaded with `RST_BASE + i`. With the defaults the registers hold 0x00A0, 0x00A1 and 0x00A2.
  - The sequence returns to its idle, locked step.
  - `wr_reject` and `bus_rdata` are cleared to 0.
- R2: When `lock_cfg` is 0, every write to a guarded address takes effect without a key, and `wr_reject` stays low.
- R3: When `lock_cfg` is 1 and no key sequence has been completed, a write to a guarded address is refused. The register keeps its value, and `wr_reject` is high for exactly the one cycle after that write.
- R4: Writing 0xABCD to address 0 and then 0x4321 to address 0 unlocks the bank. A guarded write made as the very next access is then accepted, and its data is visible on a later read.
- R5: Each unlock grants only one guarded write. A second guarded write after it is refused. Updating all three registers therefore takes three full sequences.
- R6: Any access inside the sequence returns it to idle, so the next guarded write is refused. This covers a read of any address and a write to any address other than the one expected. The intruding access may fall between the two key writes or between the second key write and the guarded write.
- R7: A key write carrying the wrong value returns the sequence to idle. A write of 0x4321 to address 0 that is not directly preceded by a write of 0xABCD does not unlock the bank.
- R8: A write of 0xABCD to address 0 restarts the sequence at its first step from any step. This holds even when the bank is already unlocked.
- R9: Reads use `bus_rdata` with a latency of one cycle:
  - A read of a guarded address returns that register's contents.
  - A read of address 0 or of an unmapped address returns 0.
  - In the cycle after any non-read, `bus_rdata` is 0.
  - A read never raises `wr_reject`.
- R10: Cycles with `bus_valid` low do not change the progress of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_cfg | input | 1 | 1 = guarded registers protected, 0 = freely writable |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Registered read data, one cycle after the read |
| wr_reject | output | 1 | One-cycle pulse after a refused guarded write |

## Verification
The bench builds the block with its defaults: 16-bit data, a 4-bit address and three guarded registers. With this build the exact key words fit the data path. The last guarded index is reachable, and addresses 4 to 15 give unmapped targets for intruding writes and reads. The parameters also keep the reset values distinct, so a write that leaks through, or one that is lost, shows up on the next read-back.

// File: rtl/keyed_pkg.sv
package keyed_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HALF = 2'd1,
    SEQ_OPEN = 2'd2
  } seq_t;
endpackage

// File: rtl/keyed_seq.sv
module keyed_seq
  import keyed_pkg::*;
#(
  parameter int          DW   = 16,
  parameter logic [DW-1:0] KEY1 = 16'hABCD,
  parameter logic [DW-1:0] KEY2 = 16'h4321
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          grant
);
  seq_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SEQ_IDLE;
    end else if (acc) begin
      if (key_wr && wdata == KEY1)
        st <= SEQ_HALF;
      else if (key_wr && wdata == KEY2 && st == SEQ_HALF)
        st <= SEQ_OPEN;
      else
        st <= SEQ_IDLE;
    end
  end

  assign grant = (st == SEQ_OPEN);
endmodule

// File: rtl/guarded_bank.sv
module guarded_bank #(
  parameter int            DW       = 16,
  parameter int            NREG     = 3,
  parameter logic [DW-1:0] RST_BASE = 16'h00A0,
  localparam int           IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RST_BASE + DW'(i);
      else if (we && widx == IW'(i))
        regs[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= regs[ridx];
    else
      rdata <= '0;
  end
endmodule

// File: rtl/keyed_reg_guard.sv
module keyed_reg_guard #(
  parameter int            AW       = 4,
  parameter int            DW       = 16,
  parameter int            NREG     = 3,
  parameter int            BASE     = 1,
  parameter logic [DW-1:0] KEY1     = 16'hABCD,
  parameter logic [DW-1:0] KEY2     = 16'h4321,
  parameter logic [DW-1:0] RST_BASE = 16'h00A0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_cfg,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wr_reject
);
  localparam int        IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + NREG);

  logic [AW:0]   addr_x;
  logic [AW:0]   off;
  logic          in_range;
  logic          key_hit;
  logic          g_wr;
  logic          g_rd;
  logic          grant;
  logic          accept;
  logic [IW-1:0] idx;

  assign addr_x   = {1'b0, bus_addr};
  assign off      = addr_x - LO;
  assign idx      = off[IW-1:0];
  assign in_range = (addr_x >= LO) && (addr_x < HI);
  assign key_hit  = bus_valid && bus_write && (bus_addr == '0);
  assign g_wr     = bus_valid && bus_write && in_range;
  assign g_rd     = bus_valid && !bus_write && in_range;
  assign accept   = g_wr && (!lock_cfg || grant);

  keyed_seq #(.DW(DW), .KEY1(KEY1), .KEY2(KEY2)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .acc   (bus_valid),
    .key_wr(key_hit),
    .wdata (bus_wdata),
    .grant (grant)
  );

  guarded_bank #(.DW(DW), .NREG(NREG), .RST_BASE(RST_BASE)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (accept),
    .widx (idx),
    .wdata(bus_wdata),
    .re   (g_rd),
    .ridx (idx),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)
      wr_reject <= 1'b0;
    else
      wr_reject <= g_wr && !accept;
  end
endmodule

// File: rtl/keyed_reg_guard_chk.sv
module keyed_reg_guard_chk #(
  parameter int AW   = 4,
  parameter int NREG = 3,
  parameter int BASE = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          lock_cfg,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          wr_reject
);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + NREG);

  logic gw;
  logic gw_locked;
  logic rd;

  assign gw        = bus_valid && bus_write && ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
  assign gw_locked = gw && lock_cfg;
  assign rd        = bus_valid && !bus_write;

  // R1
  always @(posedge clk) begin
    if (!rst && $past(rst))
      after_reset_quiet_chk: assert (!wr_reject);
  end

  // R3
  reject_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $past(gw_locked));

  // R2
  open_mode_accepts_chk: assert property (@(posedge clk) disable iff (rst)
    (gw && !lock_cfg) |=> !wr_reject);

  // R5
  single_use_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (gw_locked && $past(gw_locked)) |=> wr_reject);

  // R6
  read_breaks_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (gw_locked && $past(rd)) |=> wr_reject);

  // R9
  read_no_reject_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> !wr_reject);
endmodule

bind keyed_reg_guard keyed_reg_guard_chk #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lock_cfg (lock_cfg),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .wr_reject(wr_reject)
);

// File: tb/keyed_reg_guard_test.sv
`timescale 1ns/1ps
module keyed_reg_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_cfg = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wr_reject;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_regs [3];
  int step;
  int exp_rd;
  bit exp_rej;

  always #2 clk = ~clk;

  keyed_reg_guard uut (
    .clk(clk), .rst(rst), .lock_cfg(lock_cfg),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_reject(wr_reject)
  );

  task automatic compare(input string tag);
    checks++;
    if (int'(bus_rdata) != exp_rd) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rd[15:0]);
    end
    checks++;
    if (wr_reject != exp_rej) begin
      errors++;
      $display("FAIL %s wr_reject actual=%0b expected=%0b", tag, wr_reject, exp_rej);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int a, input int d, input string tag);
    bit gw;
    bus_valid = v;
    bus_write = w;
    bus_addr  = a[3:0];
    bus_wdata = d[15:0];
    @(posedge clk);
    exp_rej = 0;
    exp_rd  = 0;
    if (v) begin
      gw = w && a >= 1 && a <= 3;
      if (gw) begin
        if (!lock_cfg || step == 2) exp_regs[a-1] = d & 16'hFFFF;
        else exp_rej = 1;
      end
      if (!w && a >= 1 && a <= 3) exp_rd = exp_regs[a-1];
      if (w && a == 0 && d == 16'hABCD) step = 1;
      else if (w && a == 0 && d == 16'h4321 && step == 1) step = 2;
      else step = 0;
    end
    #1;
    compare(tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cyc(1, 1, a, d, tag);
  endtask
  task automatic rd(input int a, input string tag);
    cyc(1, 0, a, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, tag);
  endtask
  task automatic unlock(input string tag);
    wr(0, 16'hABCD, tag);
    wr(0, 16'h4321, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 3; i++) exp_regs[i] = 16'h00A0 + i;
    step = 0; exp_rd = 0; exp_rej = 0;
    compare("R1");
    // R1 reset values
    for (int i = 1; i <= 3; i++) rd(i, "R1");
    // R9 key and unmapped reads
    rd(0, "R9"); rd(7, "R9"); idle("R9");
    // R3 refused write
    wr(1, 16'h1111, "R3"); rd(1, "R3");
    wr(2, 16'h2A2A, "R3"); wr(3, 16'h3B3B, "R3"); rd(2, "R3"); rd(3, "R3");
    // R4 unlock
    unlock("R4"); wr(2, 16'h2222, "R4"); rd(2, "R4");
    // R5 single use and three sequences
    unlock("R5"); wr(3, 16'h3333, "R5"); wr(3, 16'h3030, "R5"); rd(3, "R5");
    unlock("R5"); wr(1, 16'h0101, "R5");
    unlock("R5"); wr(2, 16'h0202, "R5");
    unlock("R5"); wr(3, 16'h0303, "R5");
    rd(1, "R5"); rd(2, "R5"); rd(3, "R5");
    // R6 intruding accesses
    wr(0, 16'hABCD, "R6"); rd(1, "R6"); wr(0, 16'h4321, "R6"); wr(1, 16'hDEAD, "R6");
    unlock("R6"); rd(2, "R6"); wr(2, 16'hBEEF, "R6");
    wr(0, 16'hABCD, "R6"); wr(9, 16'h0000, "R6"); wr(0, 16'h4321, "R6"); wr(1, 16'hCAFE, "R6");
    unlock("R6"); wr(12, 16'h5555, "R6"); wr(3, 16'hF00D, "R6");
    unlock("R6"); rd(0, "R6"); wr(3, 16'hF00F, "R6");
    rd(1, "R6"); rd(2, "R6"); rd(3, "R6");
    // R7 wrong key
    wr(0, 16'hABCD, "R7"); wr(0, 16'h1234, "R7"); wr(0, 16'h4321, "R7"); wr(1, 16'h7777, "R7");
    wr(0, 16'h4321, "R7"); wr(2, 16'h7878, "R7");
    wr(0, 16'h1234, "R7"); wr(0, 16'h4321, "R7"); wr(3, 16'h7979, "R7");
    rd(1, "R7"); rd(2, "R7"); rd(3, "R7");
    // R8 restart
    wr(0, 16'hABCD, "R8"); wr(0, 16'hABCD, "R8"); wr(0, 16'h4321, "R8"); wr(1, 16'h8888, "R8");
    unlock("R8"); wr(0, 16'hABCD, "R8"); wr(0, 16'h4321, "R8"); wr(2, 16'h8989, "R8");
    unlock("R8"); wr(0, 16'hABCD, "R8"); wr(3, 16'h8A8A, "R8");
    rd(1, "R8"); rd(2, "R8"); rd(3, "R8");
    // R10 idle cycles inside sequence
    wr(0, 16'hABCD, "R10"); idle("R10"); idle("R10"); idle("R10");
    wr(0, 16'h4321, "R10"); idle("R10"); idle("R10"); wr(3, 16'hA0A0, "R10"); rd(3, "R10");
    // R2 protection off
    lock_cfg = 1'b0;
    wr(1, 16'h1234, "R2"); wr(1, 16'h4567, "R2"); wr(2, 16'h89AB, "R2"); wr(3, 16'hCDEF, "R2");
    rd(1, "R2"); rd(2, "R2"); rd(3, "R2");
    lock_cfg = 1'b1;
    wr(2, 16'h0BAD, "R3"); rd(2, "R3");
    // R1 reset mid-run
    wr(0, 16'hABCD, "R1"); wr(0, 16'h4321, "R1");
    rst = 1'b1; idle("R1"); idle("R1");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) exp_regs[i] = 16'h00A0 + i;
    step = 0;
    wr(1, 16'h9999, "R1");
    rd(1, "R1"); rd(2, "R1"); rd(3, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule